// File: doc/BRIEF.md
# Descriptor-Chained Buffer Copy Engine

This block is a single-channel memory-to-memory copy engine that works through a chain of descriptors held in memory. Software writes the address of the first descriptor and sets an enable bit. The engine then reads the five-word descriptor over a simple request/acknowledge memory master port and loads its channel registers from it. It copies the buffer one 32-bit word at a time, each word read from the source and then written to the destination. It then writes the first control word back into the descriptor with the completed size and a done flag, raises a sticky buffer-complete flag, and follows the next pointer.

Descriptor layout, byte offsets from the descriptor base: +0 source address, +4 destination address, +8 next-descriptor pointer, +12 control word A, +16 control word B. Control word A carries the buffer size in words in bits [15:0] and the done flag in bit 31. Bits [30:16] are passed through unchanged. Bit 0 of control word B allows the engine to go on to another descriptor. A long contiguous copy is expressed as several descriptors whose addresses continue one after another.

The register port has three word slots. Slot 0 is control, with bit 0 as the enable. Slot 1 holds the first descriptor address. Slot 2 is the interrupt status, written 1 to clear: bit 0 is buffer complete and bit 1 is chain complete.

Top module: `ll_dma_core`

## Requirements
- R1: After reset, mem_req, buf_irq and chain_irq are 0, and register slots 0 and 2 read as 0.
- R2: Writing 1 to bit 0 of slot 0 while it is clear starts the engine at the address in slot 1. Slot 0 bit 0 then reads 1. The engine first issues five reads at descriptor base +0, +4, +8, +12 and +16, in that order.
- R3: For k = 0 to size-1, with size taken from control A bits [15:0], the engine reads source+4k and then writes that word to destination+4k. Each write follows its read.
- R4: After the data beats of each buffer, the engine issues exactly one write, to descriptor base +12. The written value is {1'b1, controlA[30:16], size}, and bit 31 is the done flag.
- R5: A buffer of size 0 produces no data beats. Its write-back to base +12 is still issued.
- R6: When control B bit 0 is 1 and the next pointer is non-zero, the next descriptor is fetched from the next pointer. A chain with contiguous addresses produces one continuous copy.
- R7: When control B bit 0 is 0 or the next pointer is 0, the engine makes no further memory access after the write-back. Slot 0 bit 0 clears itself, and status bit 1 and chain_irq become 1.
- R8: The first descriptor read of the next buffer is requested in the cycle right after the write-back is accepted, whatever the state of the buffer-complete flag.
- R9: Status bit 0 (buf_irq) is set when a write-back is accepted and stays set until software writes 1 to it in slot 2. If a set and a clear fall in the same cycle, the set wins.
- R10: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register slot select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected slot |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted at this clock edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| buf_irq | output | 1 | Sticky buffer-complete flag |
| chain_irq | output | 1 | Sticky chain-complete flag |

## Verification
A software clear of the buffer-complete flag and the hardware setting that flag when a write-back is accepted can land on the same clock edge. The bench provokes this by asserting the write-1-to-clear of slot 2 in exactly the cycle in which its memory model acknowledges the final write-back of a chain. An earlier buffer in the same chain has already set the flag. The result is judged by reading slot 2 afterwards: bit 0 must still be 1, which a design that let the clear win would fail.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    localparam int AW         = 32;
    localparam int DW         = 32;
    localparam int SZW        = 16;
    localparam int RAW        = 2;
    localparam int DESC_WORDS = 5;
    localparam int IDXW       = $clog2(DESC_WORDS);
    localparam int CTLA_SLOT  = 3;
    localparam int DONE_BIT   = 31;
    localparam int LINK_BIT   = 0;
    localparam int N_IRQ      = 2;
    localparam int WORD_BYTES = DW / 8;

    localparam logic [RAW-1:0] SLOT_CTRL  = RAW'(0);
    localparam logic [RAW-1:0] SLOT_FIRST = RAW'(1);
    localparam logic [RAW-1:0] SLOT_STAT  = RAW'(2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XRD,
        ST_XWR,
        ST_WB,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] nxt;
        logic [DW-1:0] ctla;
        logic [DW-1:0] ctlb;
    } chan_regs_t;

    function automatic logic [SZW-1:0] buf_size(input logic [DW-1:0] ctla);
        return ctla[SZW-1:0];
    endfunction

    function automatic logic [DW-1:0] wb_word(input logic [DW-1:0] ctla,
                                              input logic [SZW-1:0] cnt);
        logic [DW-1:0] w;
        w = ctla;
        w[SZW-1:0] = cnt;
        w[DONE_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic chain_last(input chan_regs_t c);
        return (c.ctlb[LINK_BIT] == 1'b0) || (c.nxt == '0);
    endfunction

    function automatic logic [AW-1:0] word_ofs(input int unsigned n);
        return AW'(n * WORD_BYTES);
    endfunction

endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs
    import ll_dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           buf_set,
    input  logic           chain_set,
    output logic           start,
    output logic [AW-1:0]  first_desc,
    output logic           buf_irq,
    output logic           chain_irq
);

    logic             en_q;
    logic [AW-1:0]    first_q;
    logic [N_IRQ-1:0] stat_q;
    logic [N_IRQ-1:0] set_v;
    logic             clr_hit;

    assign set_v   = {chain_set, buf_set};
    assign clr_hit = cfg_we && (cfg_addr == SLOT_STAT);
    assign start   = cfg_we && (cfg_addr == SLOT_CTRL) && cfg_wdata[0] && !en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            first_q <= '0;
        end else begin
            if (cfg_we && (cfg_addr == SLOT_FIRST))
                first_q <= cfg_wdata;
            if (chain_set)
                en_q <= 1'b0;
            else if (start)
                en_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_stat
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (set_v[g])
                bit_q <= 1'b1;
            else if (clr_hit && cfg_wdata[g])
                bit_q <= 1'b0;
        end
        assign stat_q[g] = bit_q;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            SLOT_CTRL:  cfg_rdata[0] = en_q;
            SLOT_FIRST: cfg_rdata = first_q;
            SLOT_STAT:  cfg_rdata[N_IRQ-1:0] = stat_q;
            default:    cfg_rdata = '0;
        endcase
    end

    assign first_desc = first_q;
    assign buf_irq    = stat_q[0];
    assign chain_irq  = stat_q[1];

    // R9
    buf_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        buf_set |=> stat_q[0]);

    // R7
    chain_end_chk: assert property (@(posedge clk) disable iff (rst)
        chain_set |=> (!en_q && stat_q[1]));

    // R2
    start_en_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> en_q);

endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
    import ll_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [DW-1:0]   ld_data,
    input  logic            step,
    output chan_regs_t      regs,
    output logic [SZW-1:0]  cnt
);

    chan_regs_t     r_q;
    logic [SZW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '0;
            cnt_q <= '0;
        end else if (ld_en) begin
            cnt_q <= '0;
            case (ld_idx)
                IDXW'(0): r_q.src  <= ld_data;
                IDXW'(1): r_q.dst  <= ld_data;
                IDXW'(2): r_q.nxt  <= ld_data;
                IDXW'(CTLA_SLOT): begin
                    r_q.ctla           <= ld_data;
                    r_q.ctla[DONE_BIT] <= 1'b0;
                end
                default:  r_q.ctlb <= ld_data;
            endcase
        end else if (step) begin
            r_q.src <= r_q.src + word_ofs(1);
            r_q.dst <= r_q.dst + word_ofs(1);
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign regs = r_q;
    assign cnt  = cnt_q;

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_en) |=> (regs.src == $past(regs.src) + word_ofs(1)) &&
                             (regs.dst == $past(regs.dst) + word_ofs(1)) &&
                             (cnt == $past(cnt) + 1'b1));

    // R4
    done_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_idx == IDXW'(CTLA_SLOT)) |=> !regs.ctla[DONE_BIT]);

endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
    import ll_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   first_desc,
    input  chan_regs_t      regs,
    input  logic [SZW-1:0]  cnt,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            ld_en,
    output logic [IDXW-1:0] ld_idx,
    output logic [DW-1:0]   ld_data,
    output logic            step,
    output logic            buf_set,
    output logic            chain_set
);

    seq_state_e      state_q;
    logic [IDXW-1:0] idx_q;
    logic [AW-1:0]   cur_desc_q;
    logic [DW-1:0]   data_q;
    logic            xfer;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc_q + word_ofs(idx_q);
            end
            ST_XRD: begin
                mem_req  = 1'b1;
                mem_addr = regs.src;
            end
            ST_XWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = regs.dst;
                mem_wdata = data_q;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc_q + word_ofs(CTLA_SLOT);
                mem_wdata = wb_word(regs.ctla, cnt);
            end
            default: ;
        endcase
    end

    assign xfer      = mem_req && mem_ack;
    assign ld_en     = (state_q == ST_FETCH) && xfer;
    assign ld_idx    = idx_q;
    assign ld_data   = mem_rdata;
    assign step      = (state_q == ST_XWR) && xfer;
    assign buf_set   = (state_q == ST_WB) && xfer;
    assign chain_set = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            cur_desc_q <= '0;
            data_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_desc_q <= first_desc;
                        idx_q      <= '0;
                        state_q    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (xfer) begin
                        if (idx_q == IDXW'(DESC_WORDS - 1)) begin
                            idx_q   <= '0;
                            state_q <= (buf_size(regs.ctla) == '0) ? ST_WB : ST_XRD;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_XRD: begin
                    if (xfer) begin
                        data_q  <= mem_rdata;
                        state_q <= ST_XWR;
                    end
                end
                ST_XWR: begin
                    if (xfer)
                        state_q <= (SZW'(cnt + 1'b1) == buf_size(regs.ctla)) ? ST_WB : ST_XRD;
                end
                ST_WB: begin
                    if (xfer) begin
                        if (chain_last(regs)) begin
                            state_q <= ST_DONE;
                        end else begin
                            cur_desc_q <= regs.nxt;
                            state_q    <= ST_FETCH;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R8
    no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        buf_set |=> (state_q == ST_FETCH || state_q == ST_DONE));

    // R7
    quiet_end_chk: assert property (@(posedge clk) disable iff (rst)
        chain_set |=> !mem_req);

    // R5
    zero_size_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_idx == IDXW'(DESC_WORDS - 1) && buf_size(regs.ctla) == '0)
            |=> (state_q == ST_WB));

endmodule

// File: rtl/ll_dma_core.sv
module ll_dma_core
    import ll_dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           buf_irq,
    output logic           chain_irq
);

    logic            start;
    logic [AW-1:0]   first_desc;
    logic            buf_set;
    logic            chain_set;
    logic            ld_en;
    logic [IDXW-1:0] ld_idx;
    logic [DW-1:0]   ld_data;
    logic            step;
    chan_regs_t      regs;
    logic [SZW-1:0]  cnt;

    ll_dma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .buf_set    (buf_set),
        .chain_set  (chain_set),
        .start      (start),
        .first_desc (first_desc),
        .buf_irq    (buf_irq),
        .chain_irq  (chain_irq)
    );

    ll_dma_chan u_chan (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .step    (step),
        .regs    (regs),
        .cnt     (cnt)
    );

    ll_dma_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .first_desc (first_desc),
        .regs       (regs),
        .cnt        (cnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .ld_en      (ld_en),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .step       (step),
        .buf_set    (buf_set),
        .chain_set  (chain_set)
    );

endmodule

// File: tb/ll_dma_core_bench.sv
module ll_dma_core_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        drv_we;
    logic [1:0]  drv_addr;
    logic [31:0] drv_wdata;
    logic        coll_we;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        buf_irq, chain_irq;

    assign cfg_we    = drv_we | coll_we;
    assign cfg_addr  = coll_we ? 2'd2 : drv_addr;
    assign cfg_wdata = coll_we ? 32'h1 : drv_wdata;

    ll_dma_core u_ll_dma_core (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_irq(buf_irq), .chain_irq(chain_irq)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        bit          wb;
        bit          more;
        logic [31:0] nxt;
        bit          coll;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] mem [0:1023];
    int          n_run = 0;
    int          n_fail = 0;
    bit          stall_en = 0;
    logic [2:0]  lfsr = 3'b001;
    bit          pend_r8 = 0;
    logic [31:0] pend_nxt = '0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input string tag);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.wb = 0; e.more = 0;
        e.nxt = '0; e.coll = 0; e.tag = tag;
        expq.push_back(e);
    endtask

    // Places one descriptor in memory and queues the accesses it must cause.
    task automatic add_desc(input logic [31:0] da, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n, input logic [31:0] ca, input logic [31:0] cb,
                            input bit coll, input string ftag);
        exp_t e;
        mem[da[11:2] + 0] = s;
        mem[da[11:2] + 1] = d;
        mem[da[11:2] + 2] = n;
        mem[da[11:2] + 3] = ca;
        mem[da[11:2] + 4] = cb;
        for (int i = 0; i < 5; i++) push(1'b0, da + 32'(4 * i), '0, ftag);
        for (int k = 0; k < int'(ca[15:0]); k++) begin
            push(1'b0, s + 32'(4 * k), '0, "R3");
            push(1'b1, d + 32'(4 * k), mem[s[11:2] + 10'(k)], "R3");
        end
        e.we = 1'b1; e.addr = da + 32'd12; e.data = {1'b1, ca[30:16], ca[15:0]};
        e.wb = 1; e.more = cb[0] && (n != 0); e.nxt = n; e.coll = coll;
        e.tag = (ca[15:0] == 0) ? "R5" : "R4";
        expq.push_back(e);
    endtask

    // Memory model and scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        coll_we = 1'b0;
        mem_ack = 1'b0;
        if (!rst) begin
            if (pend_r8) // R8: next fetch requested straight after write-back
                check(mem_req && !mem_we && mem_addr == pend_nxt, "R8", "next fetch",
                      mem_addr, pend_nxt);
            pend_r8 = 0;
            if (mem_req) begin
                bit stall;
                stall = stall_en && lfsr[0];
                lfsr = {lfsr[1:0], lfsr[2] ^ lfsr[1]};
                if (!stall) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[mem_addr[11:2]];
                    if (expq.size() == 0) begin
                        check(0, "R7", "unexpected access", mem_addr, 32'h0);
                    end else begin
                        e = expq.pop_front();
                        check(mem_we == e.we && mem_addr == e.addr, e.tag, "access addr",
                              mem_addr, e.addr);
                        if (e.we)
                            check(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
                        if (e.wb) begin
                            pend_r8  = e.more;
                            pend_nxt = e.nxt;
                            if (e.coll) coll_we = 1'b1;
                        end
                    end
                    if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                end
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        drv_we = 1'b1; drv_addr = a; drv_wdata = d;
        @(negedge clk);
        drv_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        drv_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_chain();
        int t;
        t = 0;
        while (!chain_irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(chain_irq == 1'b1, "R7", "chain_irq after chain", 32'(chain_irq), 32'h1);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        mem_ack = 1'b0; mem_rdata = '0; coll_we = 1'b0;
        drv_we = 1'b0; drv_addr = '0; drv_wdata = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int i = 0; i < 64; i++) mem[256 + i] = 32'hC0DE_0000 ^ 32'(i * 32'h0101_0011);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'h0);
        check(buf_irq == 1'b0 && chain_irq == 1'b0, "R1", "irqs",
              {30'h0, chain_irq, buf_irq}, 32'h0);
        reg_rd(2'd0, rd); check(rd == 32'h0, "R1", "ctrl slot", rd, 32'h0);
        reg_rd(2'd2, rd); check(rd == 32'h0, "R1", "status slot", rd, 32'h0);

        // Single buffer, three words, chain ends on null pointer (R2, R3, R4, R7)
        add_desc(32'h100, 32'h400, 32'h800, 32'h0, 32'h0012_0003, 32'h1, 0, "R2");
        reg_wr(2'd1, 32'h100);
        reg_rd(2'd1, rd); check(rd == 32'h100, "R2", "first slot", rd, 32'h100);
        reg_wr(2'd0, 32'h1);
        reg_rd(2'd0, rd); check(rd == 32'h1, "R2", "enable set", rd, 32'h1);
        wait_chain();
        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R7", "pending accesses", 32'(expq.size()), 32'h0);
        reg_rd(2'd0, rd); check(rd == 32'h0, "R7", "enable self-clear", rd, 32'h0);
        reg_rd(2'd2, rd); check(rd == 32'h3, "R9", "status both set", rd, 32'h3);
        check(mem[(32'h800 >> 2) + 2] == mem[(32'h400 >> 2) + 2], "R3", "dest word 2",
              mem[(32'h800 >> 2) + 2], mem[(32'h400 >> 2) + 2]);
        check(mem[32'h10C >> 2] == 32'h8012_0003, "R4", "descriptor write-back",
              mem[32'h10C >> 2], 32'h8012_0003);
        reg_wr(2'd2, 32'h1);
        reg_rd(2'd2, rd); check(rd == 32'h2, "R9", "clear buf flag", rd, 32'h2);
        check(buf_irq == 1'b0, "R9", "buf_irq low", 32'(buf_irq), 32'h0);
        reg_wr(2'd2, 32'h2);
        reg_rd(2'd2, rd); check(rd == 32'h0, "R9", "clear chain flag", rd, 32'h0);

        // Contiguous chain with stalls: 2 words, zero-size, 4 words with link disabled
        // and a non-null pointer; a clear collides with the final write-back (R5, R6, R8, R9)
        stall_en = 1;
        add_desc(32'h140, 32'h400, 32'h900, 32'h180, 32'h0000_0002, 32'h1, 0, "R2");
        add_desc(32'h180, 32'h408, 32'h908, 32'h1C0, 32'h8000_0000, 32'h1, 0, "R6");
        add_desc(32'h1C0, 32'h408, 32'h908, 32'h200, 32'h0007_0004, 32'h0, 1, "R6");
        reg_wr(2'd1, 32'h140);
        reg_wr(2'd0, 32'h1);
        wait_chain();
        repeat (20) @(negedge clk);
        check(expq.size() == 0, "R7", "pending accesses", 32'(expq.size()), 32'h0);
        reg_rd(2'd2, rd); check(rd == 32'h3, "R9", "set wins over clear", rd, 32'h3);
        check(buf_irq == 1'b1, "R9", "buf_irq kept", 32'(buf_irq), 32'h1);
        for (int k = 0; k < 6; k++)
            check(mem[(32'h900 >> 2) + k] == mem[(32'h400 >> 2) + k], "R6", "contiguous copy",
                  mem[(32'h900 >> 2) + k], mem[(32'h400 >> 2) + k]);
        check(mem[32'h18C >> 2] == 32'h8000_0000, "R5", "zero-size write-back",
              mem[32'h18C >> 2], 32'h8000_0000);
        check(mem[32'h1CC >> 2] == 32'h8007_0004, "R4", "last write-back",
              mem[32'h1CC >> 2], 32'h8007_0004);
        reg_rd(2'd0, rd); check(rd == 32'h0, "R7", "enable self-clear", rd, 32'h0);

        finished = 1;
        report();
        $finish;
    end

endmodule